// File: doc/BRIEF.md
# Keyed Mailbox Port Controller

This block is a byte-wide peripheral with two registers at local offsets of a port window. The register at offset 0x4 takes a command on write and returns a status byte on read. The register at offset 0x0 is the data register. It holds a small fixed table of values, each found by a four-character key. The host fetches a value in four steps. It writes the read command, 0x10, to the command register. It writes the four key characters to the data register, then a length byte. It then reads the value back one byte per access, and polls the status byte to see progress.

The status byte takes one of four codes. 0x0C means a read command was accepted. 0x04 means a key byte was taken. 0x05 means value bytes remain. 0x00 means the stream is done. Only the read command changes how the data register behaves. Any other command byte is latched, but data accesses then do nothing.

Address decoding above the local offset belongs to the enclosing bus. The `addr` input carries only the offset inside the window.

Top module: `keyed_mailbox`

## Requirements
- R1: After reset, a read of the command register (offset 4) returns 0x00 and a read of the data register (offset 0) returns 0x00.
- R2: Any byte written to the command register becomes the current command and restarts the key-byte and output-byte counters. A write of 0x10 sets status to 0x0C. Any other value leaves status unchanged.
- R3: Under command 0x10, the first four data writes are taken as key characters in order, first character first. Each of them sets status to 0x04.
- R4: Under command 0x10, the fifth data write is the requested length. It sets status to 0x05, restarts the output pointer and looks up the captured key.
- R5: Data writes after the fifth under command 0x10 change neither the status nor the bytes streamed out.
- R6: Under command 0x10, each data read returns the next buffered byte while the pointer is below the length. After the read of the last byte, status is 0x00. After any earlier read, status is 0x05.
- R7: A data read once the pointer has reached the length returns 0x00 and leaves status unchanged.
- R8: While the current command is not 0x10, data reads return 0x00, and data writes change neither status nor the buffered value.
- R9: Reading the command register returns the status and has no side effect.
- R10: The table holds five entries. "VERS" has 6 bytes: 01 13 0F 00 00 03. "KEYA" has 32 bytes, where byte i is 3*i+1. "KEYB" has 32 bytes, where byte i is 0x80 XOR i. "FLGA" and "FLGB" each have one byte, 0x00.
- R11: A key that matches no entry leaves the buffer as it was. Reads then return the stale bytes, up to the requested length.
- R12: A requested length above 32 is treated as 32.
- R13: Accesses at offsets other than 0 and 4 read 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Offset within the port window |
| wr_en | input | 1 | One-byte write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | One-byte read strobe, one cycle per access |
| rd_data | output | 8 | Read data, valid in the cycle rd_en is high |

## Verification
Several internal faults show up at the ports within a few accesses:
- A wrong write counter makes the status code wrong at the key or length write itself.
- A bad key compare or table entry makes the first streamed byte wrong.
- An off-by-one in the output pointer shows up one byte early or late, either as the 0x00 status code or as the zero returned past the end.
- Stale-buffer handling and length clamping are visible only after a long value has been loaded first. The bench therefore sweeps every key against several lengths, in an order where each query can see what the one before it left behind.

// File: rtl/kmb_pkg.sv
// Shared constants and the fixed key/value table for the keyed mailbox.
// Assumes byte-wide accesses and four-character keys, first character in the MSB.
package kmb_pkg;
    localparam logic [7:0] CMD_READ  = 8'h10;
    localparam logic [7:0] ST_IDLE   = 8'h00;
    localparam logic [7:0] ST_KEY    = 8'h04;
    localparam logic [7:0] ST_DATA   = 8'h05;
    localparam logic [7:0] ST_ARMED  = 8'h0C;
    localparam int NUM_ENT = 5;

    // Key of table entry e.
    function automatic logic [31:0] ent_key(int e);
        case (e)
            0:       return "VERS";
            1:       return "KEYA";
            2:       return "KEYB";
            3:       return "FLGA";
            default: return "FLGB";
        endcase
    endfunction

    // Number of value bytes in entry e.
    function automatic int ent_len(int e);
        case (e)
            0:       return 6;
            1, 2:    return 32;
            default: return 1;
        endcase
    endfunction

    // Value byte i of entry e, computed rather than listed.
    function automatic logic [7:0] ent_byte(int e, int i);
        case (e)
            0: begin
                case (i)
                    0:       return 8'h01;
                    1:       return 8'h13;
                    2:       return 8'h0F;
                    5:       return 8'h03;
                    default: return 8'h00;
                endcase
            end
            1:       return 8'(3 * i + 1);
            2:       return 8'(i) ^ 8'h80;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/kmb_lookup.sv
// Combinational key match against the fixed table.
// On a hit it gives the entry length and its value bytes, zero-padded.
// The first matching entry wins; the keys are distinct, so at most one matches.
module kmb_lookup #(
    parameter int MAX_LEN = 32,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic [31:0]                key,
    output logic                       hit,
    output logic [LEN_W-1:0]           len,
    output logic [MAX_LEN-1:0][7:0]    val
);
    import kmb_pkg::*;

    logic [NUM_ENT-1:0] match;

    // One comparator per table entry.
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        assign match[e] = (key == ent_key(e));
    end

    // Select the matching entry and expand its bytes.
    always_comb begin
        hit = 1'b0;
        len = '0;
        val = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit = 1'b1;
                len = LEN_W'(ent_len(e));
                for (int i = 0; i < MAX_LEN; i++)
                    val[i] = (i < ent_len(e)) ? ent_byte(e, i) : 8'h00;
            end
        end
    end
endmodule

// File: rtl/kmb_outbuf.sv
// Output byte buffer. A load overwrites only the first ld_len bytes; the rest keep
// their old contents. Assumes ld_len <= MAX_LEN and rd_idx < MAX_LEN.
module kmb_outbuf #(
    parameter int MAX_LEN = 32,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = $clog2(MAX_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld,
    input  logic [LEN_W-1:0]           ld_len,
    input  logic [MAX_LEN-1:0][7:0]    ld_val,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [7:0]                 rd_byte
);
    logic [MAX_LEN-1:0][7:0] mem_q;

    // Partial load of the value bytes; bytes past ld_len are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (ld) begin
            for (int i = 0; i < MAX_LEN; i++)
                if (i < int'(ld_len)) mem_q[i] <= ld_val[i];
        end
    end

    // Asynchronous read of the byte under the pointer.
    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/keyed_mailbox.sv
// Keyed mailbox top: command/status register at offset 4, data register at offset 0.
// Decodes the command, steps the status codes, captures the key and length, and
// streams the looked-up value. Assumes wr_en and rd_en each mark one byte access;
// when both are high, the write alone updates state.
module keyed_mailbox #(
    parameter int OFF_W    = 3,
    parameter int MAX_LEN  = 32,
    parameter int DATA_OFF = 0,
    parameter int CMD_OFF  = 4,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] addr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data
);
    import kmb_pkg::*;

    logic [7:0]       cmd_q, status_q;
    logic [2:0]       wcnt_q;
    logic [LEN_W-1:0] rptr_q, len_q;
    logic [31:0]      key_q;

    logic             at_data, at_cmd, in_read;
    logic             cmd_wr, data_wr, len_wr, rd_ok, data_rd;
    logic [LEN_W-1:0] req_len;
    logic             lk_hit;
    logic [LEN_W-1:0] lk_len;
    logic [MAX_LEN-1:0][7:0] lk_val;
    logic [7:0]       buf_byte;

    // Access decode.
    assign at_data = (addr == OFF_W'(DATA_OFF));
    assign at_cmd  = (addr == OFF_W'(CMD_OFF));
    assign in_read = (cmd_q == CMD_READ);
    assign cmd_wr  = wr_en && at_cmd;
    assign data_wr = wr_en && at_data && in_read;
    assign len_wr  = data_wr && (wcnt_q == 3'd4);
    assign rd_ok   = at_data && in_read && (rptr_q < len_q);
    assign data_rd = rd_en && !wr_en && rd_ok;

    // Clamp the requested length to the buffer size.
    assign req_len = (wr_data > 8'(MAX_LEN)) ? LEN_W'(MAX_LEN) : LEN_W'(wr_data);

    kmb_lookup #(.MAX_LEN(MAX_LEN)) u_lookup (
        .key (key_q),
        .hit (lk_hit),
        .len (lk_len),
        .val (lk_val)
    );

    kmb_outbuf #(.MAX_LEN(MAX_LEN)) u_outbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (len_wr && lk_hit),
        .ld_len  (lk_len),
        .ld_val  (lk_val),
        .rd_idx  (rptr_q[IDX_W-1:0]),
        .rd_byte (buf_byte)
    );

    // Command latch, counters, key capture and status sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            status_q <= ST_IDLE;
            wcnt_q   <= '0;
            rptr_q   <= '0;
            len_q    <= '0;
            key_q    <= '0;
        end else if (cmd_wr) begin
            cmd_q  <= wr_data;
            wcnt_q <= '0;
            rptr_q <= '0;
            if (wr_data == CMD_READ) status_q <= ST_ARMED;
        end else if (data_wr) begin
            if (wcnt_q < 3'd4) begin
                key_q    <= {key_q[23:0], wr_data};
                status_q <= ST_KEY;
            end else if (len_wr) begin
                len_q    <= req_len;
                rptr_q   <= '0;
                status_q <= ST_DATA;
            end
            if (wcnt_q != 3'd5) wcnt_q <= wcnt_q + 3'd1;
        end else if (data_rd) begin
            rptr_q   <= rptr_q + 1'b1;
            status_q <= (rptr_q + 1'b1 == len_q) ? ST_IDLE : ST_DATA;
        end
    end

    // Read data mux.
    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            if (at_cmd)     rd_data = status_q;
            else if (rd_ok) rd_data = buf_byte;
        end
    end

    // R2: a read command arms the status.
    a_r2_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_cmd && wr_data == CMD_READ) |=> (status_q == ST_ARMED));
    // R6: status only ever holds one of the four codes.
    a_r6_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_IDLE || status_q == ST_KEY ||
         status_q == ST_DATA || status_q == ST_ARMED));
    // R6: the pointer never runs past the length.
    a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_q <= len_q);
    // R12: the stored length never exceeds the buffer.
    a_r12_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(MAX_LEN));
    // R9: a status read changes nothing.
    a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && at_cmd) |=> ($stable(status_q) && $stable(rptr_q)));
    // R8: data reads under another command return zero.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_data && !in_read) |-> (rd_data == 8'h00));
endmodule

// File: tb/tb_keyed_mailbox.sv
module tb_keyed_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_buf [32];
    logic [7:0] exp_st;

    keyed_mailbox dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                       .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

    always #10 clk = ~clk;

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // Table model built from R10.
    function automatic int mdl_idx(logic [31:0] k);
        case (k)
            "VERS":  return 0;
            "KEYA":  return 1;
            "KEYB":  return 2;
            "FLGA":  return 3;
            "FLGB":  return 4;
            default: return -1;
        endcase
    endfunction
    function automatic int mdl_len(int e);
        return (e == 0) ? 6 : (e == 1 || e == 2) ? 32 : 1;
    endfunction
    function automatic logic [7:0] mdl_byte(int e, int i);
        logic [7:0] rev [6] = '{8'h01, 8'h13, 8'h0F, 8'h00, 8'h00, 8'h03};
        if (e == 0) return rev[i];
        if (e == 1) return 8'(3 * i + 1);
        if (e == 2) return 8'h80 ^ 8'(i);
        return 8'h00;
    endfunction

    // Full query: command, key, length, optional extra writes, then nrd reads.
    task automatic query(logic [31:0] k, int req, int extra, int nrd);
        logic [7:0] v;
        int e, eff;
        wr(3'd4, 8'h10); exp_st = 8'h0C;
        rd(3'd4, v); check("R2 armed", v, exp_st);
        for (int b = 3; b >= 0; b--) begin
            wr(3'd0, k[b*8 +: 8]); exp_st = 8'h04;
            rd(3'd4, v); check("R3 key status", v, exp_st);
        end
        wr(3'd0, 8'(req)); exp_st = 8'h05;
        rd(3'd4, v); check("R4 length status", v, exp_st);
        e = mdl_idx(k);
        if (e >= 0)
            for (int i = 0; i < mdl_len(e); i++) exp_buf[i] = mdl_byte(e, i);
        eff = (req > 32) ? 32 : req;
        for (int x = 0; x < extra; x++) begin
            wr(3'd0, 8'hA5 + 8'(x));
            rd(3'd4, v); check("R5 extra write status", v, exp_st);
        end
        for (int r = 0; r < nrd; r++) begin
            rd(3'd0, v);
            if (r < eff) begin
                check((e < 0) ? "R11 stale byte" : (req > 32) ? "R12 clamped byte" : "R10 value byte",
                      v, exp_buf[r]);
                exp_st = (r == eff - 1) ? 8'h00 : 8'h05;
                rd(3'd4, v); check("R6 stream status", v, exp_st);
            end else begin
                check(req > 32 ? "R12 past cap" : "R7 past end", v, 8'h00);
                rd(3'd4, v); check("R7 status kept", v, exp_st);
            end
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int lens [9] = '{0, 1, 5, 6, 7, 31, 32, 33, 200};
        logic [31:0] keys [5] = '{"VERS", "KEYA", "KEYB", "FLGA", "FLGB"};
        for (int i = 0; i < 32; i++) exp_buf[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(3'd4, v); check("R1 reset status", v, 8'h00);
        rd(3'd0, v); check("R1 reset data", v, 8'h00);

        // Unmatched key after reset reads zeros (R11).
        query("ZZZZ", 4, 0, 5);

        // Sweep of every key against every length (R10, R12, R6, R7).
        for (int k = 0; k < 5; k++)
            for (int l = 0; l < 9; l++)
                query(keys[k], lens[l], 0, ((lens[l] > 32) ? 32 : lens[l]) + 2);

        // Stale bytes behind a short entry after a long one (R11).
        query("KEYA", 32, 0, 2);
        query("VERS", 10, 0, 12);
        query("QQQQ", 20, 0, 22);

        // Extra data writes ignored (R5).
        query("KEYB", 8, 3, 10);

        // Status read side-effect free (R9).
        query("VERS", 6, 0, 0);
        rd(3'd4, v); check("R9 status read", v, 8'h05);
        rd(3'd4, v); check("R9 status read", v, 8'h05);
        rd(3'd0, v); check("R9 stream intact", v, 8'h01);
        rd(3'd4, v); check("R9 status after", v, 8'h05);

        // Non-read command (R8).
        wr(3'd4, 8'h11);
        rd(3'd4, v); check("R8 status unchanged", v, 8'h05);
        rd(3'd0, v); check("R8 data zero", v, 8'h00);
        for (int x = 0; x < 6; x++) wr(3'd0, "KEYA" >> 0);
        rd(3'd4, v); check("R8 write ignored", v, 8'h05);
        wr(3'd4, 8'h13);
        rd(3'd0, v); check("R8 data zero 13", v, 8'h00);
        query("ABCD", 6, 0, 7);

        // Command write restarts the key counter (R2).
        wr(3'd4, 8'h10);
        wr(3'd0, "X"); wr(3'd0, "Y");
        query("FLGA", 1, 0, 2);

        // Other offsets (R13).
        rd(3'd4, v); exp_st = v;
        wr(3'd2, 8'h10);
        rd(3'd2, v); check("R13 other offset read", v, 8'h00);
        rd(3'd4, v); check("R13 status untouched", v, exp_st);
        rd(3'd0, v); check("R13 data untouched", v, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule